// File: doc/BRIEF.md
# Gated Timer/Counter with Reload

This block is one timer/counter channel of the kind found next to a small processor core. It counts either a free-running internal tick, made by dividing the block clock by a prescale factor (12 by default), or falling edges seen on an external count pin. Counting can be gated by a second pin, so that software can measure how long a pulse stays high. Hardware sets a sticky overflow flag when the count wraps. Software clears that flag through the register port.

Two operating modes exist. In the wide mode, the low and high count bytes form one up-counter, and the flag is set when it wraps to zero. In the reload mode, only the low byte counts. Each time it wraps, the low byte is refilled from the high byte, so the channel overflows with a fixed period without any software help.

Software reaches the channel through a plain register port. A write takes effect on the next clock. A read returns the addressed register combinationally.

Top module: `gtc_timer`

## Requirements
- R1: After reset every register reads zero and `ovf_flag` is low. The register map is: address 0 is control, with run at bit 0, source select at bit 1 (1 = external pin), gate at bit 2, mode at bit 3 (1 = reload mode) and the overflow flag at bit 7, and all other bits reading 0; address 1 is the low count byte; address 2 is the high count byte; address 3 reads zero.
- R2: With source select 0, counting is driven by the internal tick. In any window of 12·K consecutive clock edges with counting enabled and no count write, the count advances by exactly K, whatever the external count pin does.
- R3: With source select 1, the external count pin passes through two synchronising flops. Each 1-to-0 transition adds exactly one count, whatever the width of the pulse.
- R4: Counting takes place only while run AND (NOT gate OR gate_pin) holds, with gate_pin synchronised through two flops. With gate at 1 and run at 1, an internal-source count equals the number of 12-cycle periods for which gate_pin was high.
- R5: In wide mode, {high,low} is one 16-bit up-counter. A wrap from FFFFh to 0000h sets the overflow flag. A preload of FFD2h overflows on the 46th count, and a preload of 0000h overflows on the 65536th count.
- R6: In reload mode, only the low byte counts. When it wraps, it is loaded from the high byte, the high byte is left unchanged and the flag is set. A high/low of D2h overflows after 46 counts and again after every 46 further counts. A high/low of 00h overflows after 256 counts.
- R7: The overflow flag stays set until software writes the control register with bit 7 at 0. A write with bit 7 at 1 leaves the flag as it is. A wrap in the same cycle as a clear leaves the flag set. Counting continues after overflow.
- R8: A write to a count byte takes effect at the next clock edge and replaces any increment in that same cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register address for both writes and reads |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data for `reg_addr` |
| gate_pin | input | 1 | Hardware gate, active high, asynchronous |
| count_pin | input | 1 | External count input, asynchronous; each falling edge counts |
| ovf_flag | output | 1 | Sticky overflow flag |

## Verification
The count path is driven with narrow one-cycle pulses, wide three-cycle pulses and long pulse trains that sweep the full 256-count and 65536-count ranges. This separates miscounted edges from wrong wrap points and wrong reload values. The internal tick is measured over whole 12-cycle windows while the external pin toggles at the same time, which shows that the prescale ratio is right and that the source select works. The four combinations of run, gate and gate_pin are tried one after another, and a timed high pulse on gate_pin checks pulse-width measurement. A burst of count writes made while edges arrive every other cycle shows whether a write ever loses to an increment.

// File: rtl/gtc_pkg.sv
package gtc_pkg;

    localparam int REG_ADDR_W = 2;

    localparam logic [REG_ADDR_W-1:0] ADR_CTRL = 2'd0;
    localparam logic [REG_ADDR_W-1:0] ADR_LOW  = 2'd1;
    localparam logic [REG_ADDR_W-1:0] ADR_HIGH = 2'd2;

    // Control byte bit positions
    localparam int CB_RUN  = 0;
    localparam int CB_SRC  = 1;
    localparam int CB_GATE = 2;
    localparam int CB_MODE = 3;
    localparam int CB_OVF  = 7;

    typedef enum logic {
        MODE_WIDE   = 1'b0,
        MODE_RELOAD = 1'b1
    } cnt_mode_e;

    typedef struct packed {
        logic      ovf;
        cnt_mode_e mode;
        logic      gate;
        logic      src_ext;
        logic      run;
    } ctrl_t;

endpackage

// File: rtl/gtc_prescaler.sv
module gtc_prescaler #(
    parameter int DIV = 12
) (
    input  logic clk,
    input  logic rst_n,
    output logic tick
);
    localparam int CW = (DIV > 1) ? $clog2(DIV) : 1;
    localparam logic [CW-1:0] LAST = CW'(DIV - 1);

    logic [CW-1:0] cnt_d, cnt_q;

    always_comb begin
        tick  = (cnt_q == LAST);
        cnt_d = tick ? '0 : cnt_q + 1'b1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    generate
        if (DIV > 1) begin : g_spacing
            AST_TICK_SPACING: assert property (@(posedge clk) disable iff (!rst_n)
                tick |=> !tick); // R2
        end
    endgenerate

    AST_PRESC_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= LAST); // R2

endmodule

// File: rtl/gtc_pin_sync.sv
module gtc_pin_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pin,
    output logic level,
    output logic fall
);
    logic [STAGES:0] sh_d, sh_q;

    always_comb begin
        sh_d  = {sh_q[STAGES-1:0], pin};
        level = sh_q[STAGES-1];
        fall  = sh_q[STAGES] & ~sh_q[STAGES-1];
    end

    always_ff @(posedge clk) begin
        if (!rst_n) sh_q <= '0;
        else        sh_q <= sh_d;
    end

    AST_FALL_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        fall |=> !fall); // R3

endmodule

// File: rtl/gtc_count_core.sv
module gtc_count_core #(
    parameter int BYTE_W = 8
) (
    input  logic [BYTE_W-1:0] lo_q,
    input  logic [BYTE_W-1:0] hi_q,
    input  logic              reload_mode,
    input  logic              inc,
    output logic [BYTE_W-1:0] lo_d,
    output logic [BYTE_W-1:0] hi_d,
    output logic              wrap
);
    localparam int WIDE_W = 2 * BYTE_W;

    logic [WIDE_W:0] wide_sum;
    logic [BYTE_W:0] low_sum;

    always_comb begin
        wide_sum = {1'b0, hi_q, lo_q} + (WIDE_W+1)'(1);
        low_sum  = {1'b0, lo_q} + (BYTE_W+1)'(1);
        lo_d     = lo_q;
        hi_d     = hi_q;
        wrap     = 1'b0;
        if (inc) begin
            if (reload_mode) begin
                wrap = low_sum[BYTE_W];
                lo_d = wrap ? hi_q : low_sum[BYTE_W-1:0];
            end else begin
                wrap         = wide_sum[WIDE_W];
                {hi_d, lo_d} = wide_sum[WIDE_W-1:0];
            end
        end
    end

endmodule

// File: rtl/gtc_timer.sv
module gtc_timer
    import gtc_pkg::*;
#(
    parameter int BYTE_W      = 8,
    parameter int PRESCALE    = 12,
    parameter int SYNC_STAGES = 2
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  reg_wr,
    input  logic [REG_ADDR_W-1:0] reg_addr,
    input  logic [BYTE_W-1:0]     reg_wdata,
    output logic [BYTE_W-1:0]     reg_rdata,
    input  logic                  gate_pin,
    input  logic                  count_pin,
    output logic                  ovf_flag
);
    typedef struct packed {
        ctrl_t             ctrl;
        logic [BYTE_W-1:0] lo;
        logic [BYTE_W-1:0] hi;
    } state_t;

    state_t st_d, st_q;

    logic pre_tick, gate_lvl, gate_fall_unused, cnt_lvl_unused, cnt_fall;
    logic cnt_wr, ctrl_wr, gate_ok, src_tick, inc, wrap;
    logic [BYTE_W-1:0] lo_nx, hi_nx;

    gtc_prescaler #(.DIV(PRESCALE)) u_presc (
        .clk (clk), .rst_n (rst_n), .tick (pre_tick)
    );

    gtc_pin_sync #(.STAGES(SYNC_STAGES)) u_gate_sync (
        .clk (clk), .rst_n (rst_n), .pin (gate_pin),
        .level (gate_lvl), .fall (gate_fall_unused)
    );

    gtc_pin_sync #(.STAGES(SYNC_STAGES)) u_cnt_sync (
        .clk (clk), .rst_n (rst_n), .pin (count_pin),
        .level (cnt_lvl_unused), .fall (cnt_fall)
    );

    gtc_count_core #(.BYTE_W(BYTE_W)) u_core (
        .lo_q (st_q.lo), .hi_q (st_q.hi),
        .reload_mode (st_q.ctrl.mode == MODE_RELOAD),
        .inc (inc), .lo_d (lo_nx), .hi_d (hi_nx), .wrap (wrap)
    );

    always_comb begin
        ctrl_wr  = reg_wr && (reg_addr == ADR_CTRL);
        cnt_wr   = reg_wr && (reg_addr == ADR_LOW || reg_addr == ADR_HIGH);
        gate_ok  = st_q.ctrl.run && (!st_q.ctrl.gate || gate_lvl);
        src_tick = st_q.ctrl.src_ext ? cnt_fall : pre_tick;
        inc      = gate_ok && src_tick && !cnt_wr;

        st_d    = st_q;
        st_d.lo = lo_nx;
        st_d.hi = hi_nx;

        if (ctrl_wr) begin
            st_d.ctrl.run     = reg_wdata[CB_RUN];
            st_d.ctrl.src_ext = reg_wdata[CB_SRC];
            st_d.ctrl.gate    = reg_wdata[CB_GATE];
            st_d.ctrl.mode    = cnt_mode_e'(reg_wdata[CB_MODE]);
            st_d.ctrl.ovf     = st_q.ctrl.ovf && reg_wdata[CB_OVF];
        end
        if (reg_wr && reg_addr == ADR_LOW)  st_d.lo = reg_wdata;
        if (reg_wr && reg_addr == ADR_HIGH) st_d.hi = reg_wdata;
        if (wrap) st_d.ctrl.ovf = 1'b1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    always_comb begin
        reg_rdata = '0;
        case (reg_addr)
            ADR_CTRL: begin
                reg_rdata[CB_RUN]  = st_q.ctrl.run;
                reg_rdata[CB_SRC]  = st_q.ctrl.src_ext;
                reg_rdata[CB_GATE] = st_q.ctrl.gate;
                reg_rdata[CB_MODE] = st_q.ctrl.mode;
                reg_rdata[CB_OVF]  = st_q.ctrl.ovf;
            end
            ADR_LOW:  reg_rdata = st_q.lo;
            ADR_HIGH: reg_rdata = st_q.hi;
            default:  reg_rdata = '0;
        endcase
        ovf_flag = st_q.ctrl.ovf;
    end

    AST_HOLD_WHEN_STOPPED: assert property (@(posedge clk) disable iff (!rst_n)
        (!st_q.ctrl.run && !cnt_wr) |=> $stable({st_q.hi, st_q.lo})); // R4

    AST_WRAP_SETS_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
        wrap |=> ovf_flag); // R7

    AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (ovf_flag && !(ctrl_wr && !reg_wdata[CB_OVF])) |=> ovf_flag); // R7

    AST_WIDE_WRAP_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (wrap && st_q.ctrl.mode == MODE_WIDE) |=> ({st_q.hi, st_q.lo} == '0)); // R5

    AST_RELOAD_COPY: assert property (@(posedge clk) disable iff (!rst_n)
        (wrap && st_q.ctrl.mode == MODE_RELOAD) |=> (st_q.lo == $past(st_q.hi))); // R6

    AST_WRITE_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && reg_addr == ADR_LOW) |=> (st_q.lo == $past(reg_wdata))); // R8

endmodule

// File: tb/gtc_timer_tb.sv
module gtc_timer_tb;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       reg_wr = 1'b0;
    logic [1:0] reg_addr = 2'd0;
    logic [7:0] reg_wdata = 8'd0;
    logic [7:0] reg_rdata;
    logic       gate_pin = 1'b0;
    logic       count_pin = 1'b0;
    logic       ovf_flag;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    gtc_timer u_dut (
        .clk (clk), .rst_n (rst_n), .reg_wr (reg_wr), .reg_addr (reg_addr),
        .reg_wdata (reg_wdata), .reg_rdata (reg_rdata), .gate_pin (gate_pin),
        .count_pin (count_pin), .ovf_flag (ovf_flag)
    );

    task automatic chk(input string tag, input int got, input int exp);
        checks++;
        if (got != exp) begin
            errors++;
            $display("FAIL %s: got %0h expected %0h", tag, got, exp);
        end
    endtask

    task automatic wr(input logic [1:0] a, input logic [7:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd(input logic [1:0] a, output int d);
        reg_addr = a;
        #1;
        d = int'(reg_rdata);
    endtask

    task automatic rd16(output int d);
        int lo, hi;
        rd(2'd1, lo);
        rd(2'd2, hi);
        d = hi * 256 + lo;
    endtask

    task automatic pulses(input int n, input int half);
        for (int i = 0; i < n; i++) begin
            @(negedge clk); count_pin = 1'b1;
            repeat (half - 1) @(negedge clk);
            @(negedge clk); count_pin = 1'b0;
            repeat (half - 1) @(negedge clk);
        end
        repeat (5) @(negedge clk);
    endtask

    initial begin
        repeat (195000) @(posedge clk);
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        int v;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        for (int a = 0; a < 4; a++) begin
            rd(2'(a), v); chk("R1 reset register", v, 0);
        end
        chk("R1 reset flag", int'(ovf_flag), 0);
        wr(2'd0, 8'h0B);
        rd(2'd0, v); chk("R1 control readback", v, 8'h0B);
        rd(2'd3, v); chk("R1 address 3", v, 0);

        // R5 wide mode, external source, FFD2h preload
        wr(2'd0, 8'h03);
        wr(2'd1, 8'hD2); wr(2'd2, 8'hFF);
        pulses(45, 1);
        rd16(v); chk("R5 after 45 counts", v, 16'hFFFF);
        chk("R5 no flag before wrap", int'(ovf_flag), 0);
        pulses(1, 1);
        rd16(v); chk("R5 wrap to zero", v, 0);
        chk("R5 flag on 46th", int'(ovf_flag), 1);
        pulses(3, 1);
        rd16(v); chk("R7 counting continues", v, 3);
        chk("R7 flag sticky", int'(ovf_flag), 1);
        wr(2'd0, 8'h83);
        chk("R7 write bit7=1 keeps flag", int'(ovf_flag), 1);
        wr(2'd0, 8'h03);
        chk("R7 clear", int'(ovf_flag), 0);
        rd16(v); chk("R7 clear keeps count", v, 3);

        // R3 wide pulses count once each
        pulses(5, 3);
        rd16(v); chk("R3 wide pulses", v, 8);

        // R6 reload mode D2h
        wr(2'd0, 8'h0B);
        wr(2'd2, 8'hD2); wr(2'd1, 8'hD2);
        pulses(46, 1);
        rd(2'd1, v); chk("R6 reload low", v, 8'hD2);
        rd(2'd2, v); chk("R6 high unchanged", v, 8'hD2);
        chk("R6 flag after 46", int'(ovf_flag), 1);
        wr(2'd0, 8'h0B);
        pulses(45, 1);
        rd(2'd1, v); chk("R6 second period 45", v, 8'hFF);
        chk("R6 no flag at 45", int'(ovf_flag), 0);
        pulses(1, 1);
        rd(2'd1, v); chk("R6 second reload", v, 8'hD2);
        chk("R6 flag second period", int'(ovf_flag), 1);

        // R6 reload mode 00h -> 256 counts
        wr(2'd2, 8'h00); wr(2'd1, 8'h00); wr(2'd0, 8'h0B);
        pulses(255, 1);
        rd(2'd1, v); chk("R6 255 counts", v, 8'hFF);
        chk("R6 no flag at 255", int'(ovf_flag), 0);
        pulses(1, 1);
        rd(2'd1, v); chk("R6 256th wraps", v, 0);
        chk("R6 flag at 256", int'(ovf_flag), 1);

        // R4 gating
        wr(2'd0, 8'h07); wr(2'd1, 8'h00); wr(2'd2, 8'h00);
        pulses(10, 1);
        rd16(v); chk("R4 gate low blocks", v, 0);
        gate_pin = 1'b1; repeat (4) @(negedge clk);
        pulses(10, 1);
        rd16(v); chk("R4 gate high counts", v, 10);
        wr(2'd0, 8'h02);
        pulses(5, 1);
        rd16(v); chk("R4 run off blocks", v, 10);
        wr(2'd0, 8'h06);
        pulses(5, 1);
        rd16(v); chk("R4 run off gate high blocks", v, 10);
        wr(2'd0, 8'h03); gate_pin = 1'b0; repeat (4) @(negedge clk);
        pulses(4, 1);
        rd16(v); chk("R4 gate bit 0 ignores pin", v, 14);

        // R2 internal tick, pin toggling ignored
        wr(2'd0, 8'h00); wr(2'd1, 8'h00); wr(2'd2, 8'h10);
        wr(2'd0, 8'h01);
        for (int i = 0; i < 240; i++) begin
            count_pin = ~count_pin;
            @(negedge clk);
        end
        rd16(v); chk("R2 240 cycles", v, 16'h1014);
        repeat (60) @(negedge clk);
        rd16(v); chk("R2 60 more cycles", v, 16'h1019);
        count_pin = 1'b0;

        // R4 pulse width measurement
        wr(2'd0, 8'h05); wr(2'd1, 8'h00); wr(2'd2, 8'h00);
        repeat (4) @(negedge clk);
        rd16(v); chk("R4 measure idle", v, 0);
        gate_pin = 1'b1;
        repeat (108) @(negedge clk);
        gate_pin = 1'b0;
        repeat (6) @(negedge clk);
        rd16(v); chk("R4 pulse width 9 periods", v, 9);

        // R8 write wins over increment
        wr(2'd0, 8'h03); wr(2'd2, 8'h00);
        for (int i = 0; i < 20; i++) begin
            @(negedge clk);
            reg_wr = 1'b1; reg_addr = 2'd1; reg_wdata = 8'h40;
            count_pin = ~count_pin;
            @(posedge clk); #1;
            chk("R8 write overrides", int'(reg_rdata), 8'h40);
        end
        @(negedge clk); reg_wr = 1'b0; count_pin = 1'b0;

        // R5 wide mode from 0000h: 65536 counts
        wr(2'd0, 8'h03); wr(2'd1, 8'h00); wr(2'd2, 8'h00);
        pulses(65535, 1);
        rd16(v); chk("R5 65535 counts", v, 16'hFFFF);
        chk("R5 no flag at 65535", int'(ovf_flag), 0);
        pulses(1, 1);
        rd16(v); chk("R5 65536th wraps", v, 0);
        chk("R5 flag at 65536", int'(ovf_flag), 1);

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule